// File: doc/BRIEF.md
# Single-Bus Three-Operand ALU Sequencer

This block runs one register-to-register operation of the form Rz = f(Rx, Ry) on a datapath whose parts all share one 32-bit bus. The datapath has an eight-entry register file, an ALU and two holding registers. The register file reads without a clock and writes on a clock edge. A 2:1 mux drives the bus from either the register-file read port or the ALU's output holding register. One holding register sits on the ALU's first input. The ALU takes its second input straight from the bus. The second holding register captures the ALU result. Because of this arrangement, the bus carries at most one value in any cycle.

A start pulse loads the opcode and three register indices. The controller then steps through a fixed sequence of three cycles:
1. The first operand is read onto the bus and captured in the input holding register.
2. The second operand is read onto the bus while the ALU result is captured in the output holding register.
3. The mux turns to the ALU side and the result is written back to Rz. Done is raised in this cycle.

The control strobes, the register index and the bus value are all visible at the ports. A caller checks results by running later operations that read the written registers. After reset, register k holds (k+1)·INIT_STEP, truncated to the data width. This gives the datapath known values without a separate load path.

Top module: `obd_top`

## Requirements
- R1: While reset is low, and in every idle cycle, done, rd_en, wr_en, sel_alu, ld_a, ld_b and ld_c are 0, reg_idx is 0, and bus_data is 0.
- R2: In the first cycle after a start is accepted, reg_idx = Rx, rd_en = 1, ld_a = 1, sel_alu = 0, and bus_data equals the current contents of Rx.
- R3: In the second cycle, reg_idx = Ry, rd_en = 1, ld_c = 1, sel_alu = 0, and bus_data equals the current contents of Ry.
- R4: In the third cycle, reg_idx = Rz, wr_en = 1, sel_alu = 1, rd_en = 0, done = 1 for that single cycle, and bus_data equals the ALU result. The controller is idle in the next cycle.
- R5: The opcode selects the result, with a = Rx and b = Ry: 3'b000 gives a+b, 3'b001 gives a−b, 3'b010 gives a AND b, 3'b011 gives a OR b, 3'b100 gives a XOR b, 3'b101 gives a, and 3'b110 and 3'b111 give 0. Sums and differences wrap modulo 2^32.
- R6: The result is stored in Rz at the end of the third cycle, and any later read of Rz returns it.
- R7: A start that arrives while a sequence is running is ignored. The running sequence keeps its latched opcode and indices. A start seen in an idle cycle begins a new sequence on the next cycle.
- R8: When Rz equals Rx or Ry, or when all three are equal, the result is still computed from the operand values held before the write.
- R9: ld_b is never asserted. At most one of ld_a, ld_b and ld_c is high in any cycle. rd_en and wr_en are never high together.
- R10: After reset, register k holds (k+1)·INIT_STEP truncated to 32 bits, with INIT_STEP = 32'h0101_0107 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts an operation when the controller is idle |
| op | input | 3 | ALU operation code |
| rx | input | 3 | First operand register index |
| ry | input | 3 | Second operand register index |
| rz | input | 3 | Destination register index |
| done | output | 1 | High in the write-back cycle |
| rd_en | output | 1 | Register-file read enable |
| wr_en | output | 1 | Register-file write enable |
| reg_idx | output | 3 | Register-file index in use this cycle |
| sel_alu | output | 1 | Bus mux select, 1 selects the ALU output holding register |
| ld_a | output | 1 | Load strobe of the ALU input holding register |
| ld_b | output | 1 | Load strobe of the unused second input holding register, always 0 |
| ld_c | output | 1 | Load strobe of the ALU output holding register |
| bus_data | output | 32 | Value on the shared bus |

## Verification
The case that is hardest to reach from the ports is a write-back whose destination register is also a source: the correct operand must already be in a holding register before the write edge. A second hard case is a start pulse that lands in the middle of a running sequence. The stimulus chains operations whose destination equals Rx, Ry or both. It then reads the same register back with pass operations, so any stale or clobbered value shows up on the bus. It also holds start high through whole sequences while changing the indices, so a sequence that restarts or picks up the new indices would differ from the cycle-by-cycle model.

// File: rtl/obd_pkg.sv
package obd_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'b000,
      OP_SUB  = 3'b001,
      OP_AND  = 3'b010,
      OP_OR   = 3'b011,
      OP_XOR  = 3'b100,
      OP_PASS = 3'b101
   } alu_op_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_OPA  = 2'd1,
      PH_OPB  = 2'd2,
      PH_WB   = 2'd3
   } phase_e;

   typedef struct packed {
      logic rd_en;
      logic wr_en;
      logic sel_alu;
      logic ld_a;
      logic ld_c;
      logic done;
   } ctl_s;

endpackage

// File: rtl/obd_regfile.sv
module obd_regfile #(
   parameter int          W         = 32,
   parameter int          NREG      = 8,
   parameter logic [31:0] INIT_STEP = 32'h0101_0107,
   localparam int         IW        = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic          wr_en,
   input  logic [IW-1:0] idx,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] mem [NREG];

   for (genvar k = 0; k < NREG; k++) begin : g_ent
      localparam logic [W-1:0] RST_VAL = W'((k + 1) * INIT_STEP);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[k] <= RST_VAL;
         else if (wr_en && (idx == IW'(k)))
            mem[k] <= wdata;
      end
   end

   assign rdata = rd_en ? mem[idx] : '0;

endmodule

// File: rtl/obd_hold.sv
module obd_hold #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (ld)
         q <= d;
   end

endmodule

// File: rtl/obd_alu.sv
module obd_alu #(
   parameter int W = 32
) (
   input  logic [2:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   import obd_pkg::*;

   always_comb begin
      case (alu_op_e'(op))
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_PASS: y = a;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/obd_ctrl.sv
module obd_ctrl #(
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [2:0]    op_in,
   input  logic [IW-1:0] rx,
   input  logic [IW-1:0] ry,
   input  logic [IW-1:0] rz,
   output obd_pkg::ctl_s ctl,
   output logic [IW-1:0] idx,
   output logic [2:0]    op_q
);
   import obd_pkg::*;

   phase_e        ph_q, ph_d;
   logic [IW-1:0] rx_q, ry_q, rz_q;

   always_comb begin
      case (ph_q)
         PH_IDLE: ph_d = start ? PH_OPA : PH_IDLE;
         PH_OPA:  ph_d = PH_OPB;
         PH_OPB:  ph_d = PH_WB;
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= PH_IDLE;
         rx_q <= '0;
         ry_q <= '0;
         rz_q <= '0;
         op_q <= '0;
      end else begin
         ph_q <= ph_d;
         if (ph_q == PH_IDLE && start) begin
            rx_q <= rx;
            ry_q <= ry;
            rz_q <= rz;
            op_q <= op_in;
         end
      end
   end

   always_comb begin
      ctl = '0;
      idx = '0;
      case (ph_q)
         PH_OPA: begin
            ctl.rd_en = 1'b1;
            ctl.ld_a  = 1'b1;
            idx       = rx_q;
         end
         PH_OPB: begin
            ctl.rd_en = 1'b1;
            ctl.ld_c  = 1'b1;
            idx       = ry_q;
         end
         PH_WB: begin
            ctl.wr_en   = 1'b1;
            ctl.sel_alu = 1'b1;
            ctl.done    = 1'b1;
            idx         = rz_q;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/obd_top.sv
module obd_top #(
   parameter int          W         = 32,
   parameter int          NREG      = 8,
   parameter logic [31:0] INIT_STEP = 32'h0101_0107,
   localparam int         IW        = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [2:0]    op,
   input  logic [IW-1:0] rx,
   input  logic [IW-1:0] ry,
   input  logic [IW-1:0] rz,
   output logic          done,
   output logic          rd_en,
   output logic          wr_en,
   output logic [IW-1:0] reg_idx,
   output logic          sel_alu,
   output logic          ld_a,
   output logic          ld_b,
   output logic          ld_c,
   output logic [W-1:0]  bus_data
);
   import obd_pkg::*;

   if (W < 8) begin : g_bad_width
      $error("obd_top: W must be at least 8");
   end
   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_depth
      $error("obd_top: NREG must be a power of two, at least 2");
   end

   ctl_s         ctl;
   logic [2:0]   op_q;
   logic [W-1:0] rf_q, a_q, c_q, alu_y;

   obd_ctrl #(.IW(IW)) ctrl_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .op_in (op),
      .rx    (rx),
      .ry    (ry),
      .rz    (rz),
      .ctl   (ctl),
      .idx   (reg_idx),
      .op_q  (op_q)
   );

   obd_regfile #(.W(W), .NREG(NREG), .INIT_STEP(INIT_STEP)) rf_i (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_en (ctl.rd_en),
      .wr_en (ctl.wr_en),
      .idx   (reg_idx),
      .wdata (bus_data),
      .rdata (rf_q)
   );

   obd_hold #(.W(W)) hold_a_i (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ctl.ld_a),
      .d     (bus_data),
      .q     (a_q)
   );

   obd_alu #(.W(W)) alu_i (
      .op (op_q),
      .a  (a_q),
      .b  (bus_data),
      .y  (alu_y)
   );

   obd_hold #(.W(W)) hold_c_i (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ctl.ld_c),
      .d     (alu_y),
      .q     (c_q)
   );

   assign bus_data = ctl.sel_alu ? c_q : rf_q;
   assign rd_en    = ctl.rd_en;
   assign wr_en    = ctl.wr_en;
   assign sel_alu  = ctl.sel_alu;
   assign ld_a     = ctl.ld_a;
   assign ld_b     = 1'b0;
   assign ld_c     = ctl.ld_c;
   assign done     = ctl.done;

endmodule

// File: rtl/obd_checker.sv
module obd_checker (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic done,
   input logic rd_en,
   input logic wr_en,
   input logic sel_alu,
   input logic ld_a,
   input logic ld_b,
   input logic ld_c
);

   AST_ONE_LOAD:    assert property (@(posedge clk) disable iff (!rst_n) $onehot0({ld_a, ld_b, ld_c}));     // R9
   AST_NO_B_LOAD:   assert property (@(posedge clk) disable iff (!rst_n) !ld_b);                            // R9
   AST_RD_WR_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) !(rd_en && wr_en));                // R9
   AST_A_THEN_C:    assert property (@(posedge clk) disable iff (!rst_n) ld_a |=> (ld_c && rd_en));         // R3
   AST_C_THEN_WB:   assert property (@(posedge clk) disable iff (!rst_n) ld_c |=> (wr_en && sel_alu && done)); // R4
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                   // R4
   AST_NO_RESTART:  assert property (@(posedge clk) disable iff (!rst_n) (ld_a && start) |=> !ld_a);        // R7
   AST_WB_SEL:      assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (sel_alu && !rd_en));    // R4

endmodule

bind obd_top obd_checker chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .done    (done),
   .rd_en   (rd_en),
   .wr_en   (wr_en),
   .sel_alu (sel_alu),
   .ld_a    (ld_a),
   .ld_b    (ld_b),
   .ld_c    (ld_c)
);

// File: tb/obd_top_tb.sv
module obd_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] STEP = 32'h0101_0107;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = '0, rx = '0, ry = '0, rz = '0;
   logic        done, rd_en, wr_en, sel_alu, ld_a, ld_b, ld_c;
   logic [2:0]  reg_idx;
   logic [31:0] bus_data;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   string scen = "R1";

   // behavioural reference state
   logic [31:0] m_reg [8];
   int          m_ph = 0;
   logic [2:0]  m_op, m_x, m_y, m_z;
   logic [31:0] m_a, m_c;

   always #(CLK_PERIOD / 2) clk = ~clk;

   obd_top dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rx(rx), .ry(ry), .rz(rz),
      .done(done), .rd_en(rd_en), .wr_en(wr_en), .reg_idx(reg_idx), .sel_alu(sel_alu),
      .ld_a(ld_a), .ld_b(ld_b), .ld_c(ld_c), .bus_data(bus_data)
   );

   function automatic logic [31:0] ref_f(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
      case (o)
         3'd0: return a + b;
         3'd1: return a - b;
         3'd2: return a & b;
         3'd3: return a | b;
         3'd4: return a ^ b;
         3'd5: return a;
         default: return 32'd0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0;
         for (int k = 0; k < 8; k++) m_reg[k] = 32'((k + 1) * STEP);
      end else begin
         case (m_ph)
            0: if (start) begin
                  m_ph = 1; m_op = op; m_x = rx; m_y = ry; m_z = rz;
               end
            1: begin m_a = m_reg[m_x]; m_ph = 2; end
            2: begin m_c = ref_f(m_op, m_a, m_reg[m_y]); m_ph = 3; end
            default: begin m_reg[m_z] = m_c; m_ph = 0; end
         endcase
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s (%s) %s: actual %h expected %h at %0t", req, scen, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      logic [6:0] ctl_act;
      logic [6:0] ctl_exp;
      logic [2:0] idx_exp;
      logic [31:0] bus_exp;
      string req;
      ctl_act = {done, rd_en, wr_en, sel_alu, ld_a, ld_b, ld_c};
      case (m_ph)
         1: begin ctl_exp = 7'b0100100; idx_exp = m_x; bus_exp = m_reg[m_x]; req = "R2"; end
         2: begin ctl_exp = 7'b0100001; idx_exp = m_y; bus_exp = m_reg[m_y]; req = "R3"; end
         3: begin ctl_exp = 7'b1011000; idx_exp = m_z; bus_exp = m_c;        req = "R5"; end
         default: begin ctl_exp = 7'b0; idx_exp = 3'd0; bus_exp = 32'd0; req = "R1"; end
      endcase
      chk(req == "R5" ? "R4" : req, "controls", 32'(ctl_act), 32'(ctl_exp));
      chk(req == "R5" ? "R4" : req, "reg_idx", 32'(reg_idx), 32'(idx_exp));
      chk(req, "bus_data", bus_data, bus_exp);
      if (ld_b !== 1'b0) chk("R9", "ld_b", 32'(ld_b), 32'd0);
   end

   task automatic issue(input logic [2:0] o, input logic [2:0] x, input logic [2:0] y, input logic [2:0] z);
      @(negedge clk);
      start = 1'b1; op = o; rx = x; ry = y; rz = z;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 3 + 2);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R10: read reset contents through pass operations
      scen = "R10";
      for (int k = 0; k < 8; k++) issue(3'd5, 3'(k), 3'(k), 3'(k));
      // R5: every opcode, distinct operand pairs
      scen = "R5";
      for (int o = 0; o < 8; o++) issue(3'(o), 3'(o), 3'((o + 3) % 8), 3'd7);
      issue(3'd1, 3'd0, 3'd6, 3'd7);   // subtraction wrapping below zero
      // R6: results stored and read back later
      scen = "R6";
      issue(3'd0, 3'd1, 3'd2, 3'd3);
      issue(3'd4, 3'd3, 3'd1, 3'd4);
      issue(3'd5, 3'd4, 3'd0, 3'd0);
      issue(3'd5, 3'd3, 3'd3, 3'd6);
      // R8: destination aliases a source
      scen = "R8";
      issue(3'd0, 3'd2, 3'd5, 3'd2);
      issue(3'd1, 3'd6, 3'd2, 3'd2);
      issue(3'd0, 3'd2, 3'd2, 3'd2);
      issue(3'd4, 3'd5, 3'd5, 3'd5);
      issue(3'd5, 3'd2, 3'd2, 3'd1);
      issue(3'd5, 3'd5, 3'd5, 3'd1);
      // R7: start held high while indices change mid-sequence
      scen = "R7";
      @(negedge clk);
      start = 1'b1; op = 3'd0; rx = 3'd1; ry = 3'd2; rz = 3'd3;
      @(negedge clk);
      op = 3'd3; rx = 3'd7; ry = 3'd6; rz = 3'd5;
      @(negedge clk);
      op = 3'd2; rx = 3'd4; ry = 3'd4; rz = 3'd4;
      @(negedge clk);
      op = 3'd1; rx = 3'd3; ry = 3'd0; rz = 3'd6;
      repeat (4) @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
      issue(3'd5, 3'd6, 3'd6, 3'd6);
      issue(3'd5, 3'd5, 3'd5, 3'd5);
      // R1: reset mid-sequence returns to idle and reset contents
      scen = "R1";
      @(negedge clk);
      start = 1'b1; op = 3'd0; rx = 3'd1; ry = 3'd1; rz = 3'd1;
      @(negedge clk);
      start = 1'b0;
      #(CLK_PERIOD / 4) rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "done in reset", 32'(done), 32'd0);
      chk("R1", "bus in reset", bus_data, 32'd0);
      #(CLK_PERIOD / 4) rst_n = 1'b1;
      repeat (2) @(negedge clk);
      scen = "R10";
      issue(3'd5, 3'd1, 3'd1, 3'd1);
      repeat (2) @(negedge clk);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule